// File: doc/BRIEF.md
# SIMD Processor-Enable Mask Stack

This block holds the enable vector for an array of N_PE processing elements in a single-instruction, multiple-data machine. The control sequencer issues one mask operation per cycle. Each operation chooses an operand from one of four sources: a general N-bit mask, a decoded address pattern, the captured per-element condition bits, or all ones. The operation then loads that operand into the current enable vector, ORs or ANDs it in, or opens, inverts or closes a nested conditional region. The current top of a parameterised stack is driven out as the enable vector that travels with every instruction word placed into the broadcast queue.

The elements return one condition bit each. When a capture strobe is asserted, the block registers these bits. From the captured bits and the current enable vector it drives two flags, any and all, which feed the sequencer's conditional branches. Nesting too deep or closing too many regions raises a one-cycle error pulse and leaves the stack as it was.

Top module: `simd_mask_stack`

## Requirements
- R1: After reset, pe_enable is all ones, depth is 0, stack_err is 0, and the captured condition register is all zeros.
- R2: op=1 (LOAD) replaces the top of the stack with the operand. With src=0 the operand is gen_mask unchanged, and bit i set enables element i. With src=3 the operand is all ones.
- R3: With src=1 the operand is a decoded address pattern. Bit i is 1 exactly when ((i XOR addr_val) AND NOT addr_dc) is zero, so each 1 bit in addr_dc makes that index bit a don't-care.
- R4: op=2 ORs the operand into the top, giving the union of element sets. op=3 ANDs the operand into the top.
- R5: op=4 (PUSH) writes (top AND operand) as a new top entry and increments depth. op=6 (POP) decrements depth, so the entry beneath comes back as pe_enable.
- R6: op=5 (ELSE) at depth greater than 0 replaces the top with (entry beneath AND NOT operand). Depth does not change.
- R7: PUSH at depth DEPTH-1, and POP or ELSE at depth 0, leave the stack and depth untouched and pulse stack_err high for exactly the following cycle.
- R8: A cycle with cond_load=1 registers cond_in. src=2 then selects the registered bits as the operand.
- R9: cond_any is 1 when some enabled element has its captured bit set. cond_all is 1 when no enabled element has its captured bit clear, which includes the case where no element is enabled.
- R10: op=0 (and the unused code 7) changes neither pe_enable nor depth.
- R11: All outputs are registered or are functions of registers only. A result becomes visible in the cycle after the clock edge that accepts the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Mask operation: 0 none, 1 load, 2 or, 3 and, 4 push, 5 else, 6 pop |
| src | input | 2 | Operand source: 0 general, 1 address pattern, 2 captured condition, 3 all ones |
| gen_mask | input | N_PE | General mask operand |
| addr_val | input | log2(N_PE) | Address pattern value |
| addr_dc | input | log2(N_PE) | Address pattern don't-care bits |
| cond_in | input | N_PE | Per-element condition bits |
| cond_load | input | 1 | Capture cond_in this cycle |
| pe_enable | output | N_PE | Current top-of-stack enable vector |
| depth | output | log2(DEPTH) | Index of the current top entry |
| stack_err | output | 1 | One-cycle overflow/underflow pulse |
| cond_any | output | 1 | Some enabled element true |
| cond_all | output | 1 | Every enabled element true |

## Verification
The bench fills the stack to its last slot, pushes once more, then pops it empty and tries both POP and ELSE at depth 0. A design with an off-by-one depth check would corrupt an entry or wrap the depth counter instead of pulsing the error. ELSE is checked against the entry beneath the top, not the top itself. A design that inverted the wrong entry would leave the false branch empty. The any/all flags are tested with no element enabled, where all must read 1 and any must read 0, and with condition bits that are set only on disabled elements. A design that ignored the enable vector would report a branch that no active element took.

// File: rtl/simd_mask_stack.sv
module simd_mask_stack #(
  parameter int N_PE  = 16,
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [2:0]               op,
  input  logic [1:0]               src,
  input  logic [N_PE-1:0]          gen_mask,
  input  logic [$clog2(N_PE)-1:0]  addr_val,
  input  logic [$clog2(N_PE)-1:0]  addr_dc,
  input  logic [N_PE-1:0]          cond_in,
  input  logic                     cond_load,
  output logic [N_PE-1:0]          pe_enable,
  output logic [$clog2(DEPTH)-1:0] depth,
  output logic                     stack_err,
  output logic                     cond_any,
  output logic                     cond_all
);
  localparam int AW = $clog2(N_PE);
  localparam int LW = $clog2(DEPTH);
  localparam logic [LW-1:0] LAST = LW'(DEPTH - 1);

  logic [N_PE-1:0] stk [DEPTH];
  logic [N_PE-1:0] dc_q, dec, opnd, top, below;
  logic [LW-1:0]   lvl;
  logic            err_q;

  for (genvar i = 0; i < N_PE; i++) begin : g_dec
    assign dec[i] = (((AW'(i)) ^ addr_val) & ~addr_dc) == '0;
  end

  assign top   = stk[lvl];
  assign below = (lvl == '0) ? top : stk[lvl - 1'b1];

  always_comb begin
    case (src)
      2'd0:    opnd = gen_mask;
      2'd1:    opnd = dec;
      2'd2:    opnd = dc_q;
      default: opnd = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stk[k] <= (k == 0) ? '1 : '0;
      lvl   <= '0;
      err_q <= 1'b0;
      dc_q  <= '0;
    end else begin
      err_q <= 1'b0;
      if (cond_load) dc_q <= cond_in;
      case (op)
        3'd1: stk[lvl] <= opnd;
        3'd2: stk[lvl] <= top | opnd;
        3'd3: stk[lvl] <= top & opnd;
        3'd4: if (lvl != LAST) begin
                stk[lvl + 1'b1] <= top & opnd;
                lvl <= lvl + 1'b1;
              end else err_q <= 1'b1;
        3'd5: if (lvl != '0) stk[lvl] <= below & ~opnd;
              else err_q <= 1'b1;
        3'd6: if (lvl != '0) lvl <= lvl - 1'b1;
              else err_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign pe_enable = top;
  assign depth     = lvl;
  assign stack_err = err_q;
  assign cond_any  = |(dc_q & top);
  assign cond_all  = &(dc_q | ~top);

  assert_level_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= LAST);
  assert_push_narrows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4 && lvl != LAST) |=>
      ((pe_enable & ~$past(pe_enable)) == '0) && (depth == $past(depth) + 1'b1));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd4 && lvl == LAST) |=> stack_err && $stable(pe_enable) && $stable(depth));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((op == 3'd6 || op == 3'd5) && lvl == '0) |=> stack_err && $stable(pe_enable) && $stable(depth));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'd0) |=> $stable(pe_enable) && $stable(depth) && !stack_err);
  assert_any_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_all && pe_enable != '0) |-> cond_any);
endmodule

// File: tb/sim_simd_mask_stack.sv
module sim_simd_mask_stack;
  localparam int N = 16;
  localparam int D = 4;
  localparam int AW = 4;

  logic clk = 0, rst_n = 0;
  logic [2:0] op = 0;
  logic [1:0] src = 0;
  logic [N-1:0] gen_mask = 0, cond_in = 0;
  logic [AW-1:0] addr_val = 0, addr_dc = 0;
  logic cond_load = 0;
  logic [N-1:0] pe_enable;
  logic [1:0] depth;
  logic stack_err, cond_any, cond_all;

  always #2 clk = ~clk;

  simd_mask_stack #(.N_PE(N), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .op(op), .src(src), .gen_mask(gen_mask),
    .addr_val(addr_val), .addr_dc(addr_dc), .cond_in(cond_in), .cond_load(cond_load),
    .pe_enable(pe_enable), .depth(depth), .stack_err(stack_err),
    .cond_any(cond_any), .cond_all(cond_all));

  typedef struct packed {
    logic [N-1:0] en;
    logic [1:0]   lv;
    logic         er;
    logic         an;
    logic         al;
  } item_t;

  item_t exp_q[$];
  string tag_q[$];
  int compared = 0, mismatched = 0;
  bit done = 0;

  logic [N-1:0] ms [D];
  int mlv = 0;
  logic [N-1:0] mdc = 0;

  function automatic item_t snap(bit er);
    item_t t;
    t.en = ms[mlv];
    t.lv = 2'(mlv);
    t.er = er;
    t.an = |(mdc & ms[mlv]);
    t.al = &(mdc | ~ms[mlv]);
    return t;
  endfunction

  task automatic run(input logic [2:0] o, input logic [1:0] s, input logic [N-1:0] g,
                     input logic [AW-1:0] av, input logic [AW-1:0] ad,
                     input bit ld, input logic [N-1:0] ci, input string tag);
    logic [N-1:0] opv;
    bit er;
    @(negedge clk);
    op = o; src = s; gen_mask = g; addr_val = av; addr_dc = ad; cond_load = ld; cond_in = ci;
    case (s)
      2'd0: opv = g;
      2'd1: for (int i = 0; i < N; i++) opv[i] = ((4'(i) ^ av) & ~ad) == 4'd0;
      2'd2: opv = mdc;
      default: opv = '1;
    endcase
    er = 0;
    case (o)
      3'd1: ms[mlv] = opv;
      3'd2: ms[mlv] = ms[mlv] | opv;
      3'd3: ms[mlv] = ms[mlv] & opv;
      3'd4: if (mlv < D - 1) begin ms[mlv + 1] = ms[mlv] & opv; mlv++; end else er = 1;
      3'd5: if (mlv > 0) ms[mlv] = ms[mlv - 1] & ~opv; else er = 1;
      3'd6: if (mlv > 0) mlv--; else er = 1;
      default: ;
    endcase
    if (ld) mdc = ci;
    @(posedge clk);
    #1;
    exp_q.push_back(snap(er));
    tag_q.push_back(tag);
    @(negedge clk);
    op = 0; cond_load = 0;
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '{pe_enable, depth, stack_err, cond_any, cond_all};
      compared++;
      if (a !== e) begin
        mismatched++;
        $display("FAIL %s: actual en=%h lv=%0d err=%b any=%b all=%b expected en=%h lv=%0d err=%b any=%b all=%b",
                 t, a.en, a.lv, a.er, a.an, a.al, e.en, e.lv, e.er, e.an, e.al);
      end
    end
  end

  initial begin
    #80000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    ms[0] = '1; for (int k = 1; k < D; k++) ms[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    exp_q.push_back(snap(0)); tag_q.push_back("R1 reset");
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    run(1, 0, 16'hA5C3, 0, 0, 0, 0, "R2 load general");
    run(2, 0, 16'h0F00, 0, 0, 0, 0, "R4 or");
    run(3, 0, 16'hFFF0, 0, 0, 0, 0, "R4 and");
    run(0, 0, 16'h1234, 0, 0, 0, 0, "R10 idle");
    run(7, 0, 16'h1234, 0, 0, 0, 0, "R10 unused code");
    run(1, 1, 0, 4'd5, 4'd0, 0, 0, "R3 exact address");
    run(2, 1, 0, 4'd0, 4'd3, 0, 0, "R3 R4 address union");
    run(1, 3, 0, 0, 0, 0, 0, "R2 all ones");
    run(3, 1, 0, 4'd8, 4'd7, 0, 0, "R3 upper half");
    run(1, 3, 0, 0, 0, 1, 16'h00FF, "R8 capture");
    run(4, 2, 0, 0, 0, 0, 0, "R5 R8 push cond");
    run(5, 2, 0, 0, 0, 0, 0, "R6 else");
    run(4, 0, 16'h0F0F, 0, 0, 0, 0, "R5 push 2");
    run(4, 0, 16'h3333, 0, 0, 0, 0, "R5 push 3");
    run(4, 0, 16'hFFFF, 0, 0, 0, 0, "R7 overflow");
    run(0, 0, 0, 0, 0, 0, 0, "R7 pulse ends");
    run(6, 0, 0, 0, 0, 0, 0, "R5 pop 1");
    run(6, 0, 0, 0, 0, 0, 0, "R5 pop 2");
    run(6, 0, 0, 0, 0, 0, 0, "R5 pop 3");
    run(6, 0, 0, 0, 0, 0, 0, "R7 pop underflow");
    run(5, 0, 16'h00FF, 0, 0, 0, 0, "R7 else underflow");
    run(0, 0, 0, 0, 0, 1, 16'h0000, "R9 none true");
    run(0, 0, 0, 0, 0, 1, 16'hFFFF, "R9 all true");
    run(1, 0, 16'h0000, 0, 0, 1, 16'h0000, "R9 none enabled");
    run(1, 0, 16'h0010, 0, 0, 1, 16'h0010, "R9 single enabled true");
    run(0, 0, 0, 0, 0, 1, 16'hFFEF, "R9 only disabled true");
    run(0, 0, 0, 0, 0, 0, 0, "R11 settle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule